// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Thresholds

This block holds the sample queues that sit between a register bus and the slot generator of a serial audio port. It has two queues. The transmit queue is filled by bus writes and drained one word at a time by the slot generator. The receive queue is filled by the slot generator and drained by bus reads. A single control/status word sets the enable and direction bits and reports occupancy flags and sticky error flags. A second word holds four occupancy thresholds. These thresholds drive a request line and a panic line for each direction, which feed an external DMA engine.

The audio side runs from a slow bit clock, presented here as a one-cycle strobe `bclk_tick` in the system clock domain. A queue clear does not happen at once. It completes only after a fixed number of bit-clock strobes. A sync flag offers a way to confirm this: when software writes it with a new value, the new value reads back only after the same number of strobes. Software toggles the flag, then polls until the readback matches, and by then any clear issued with it has finished.

Top module: `afq_top`

## Requirements
- R1: After reset, the control/status word (address 0) reads with only bits 17, 18, 19 and 21 set, the threshold word (address 2) reads 0, and all four DMA outputs are low.
- R2: A bus write to address 1 appends to the transmit queue. `tx_word` shows the oldest transmit word, and `tx_word_req` removes it. `rx_word_vld` appends `rx_word` to the receive queue. A bus read of address 1 returns the oldest receive word in the same cycle and removes it. Order is first in, first out.
- R3: `tx_word_req` is ignored unless bit 0 (enable) and bit 2 (transmit on) are both set. `rx_word_vld` is ignored unless bit 0 and bit 1 (receive on) are both set.
- R4: Bit 15 becomes set when a bus write hits a full transmit queue (the word is dropped) or when a pop hits an empty one. Bit 16 becomes set on a push to a full receive queue or a bus read of an empty one. Both bits stay set until a 1 is written to them.
- R5: Writing 1 to bit 3 (transmit) or bit 4 (receive) empties that queue on the CLR_TICKS-th `bclk_tick` after the write, and not before. Both bits read as 0.
- R6: A value written to bit 24 reads back on bit 24 only from the CLR_TICKS-th `bclk_tick` after the write. Until then the previous value is read.
- R7: Status bits of the control/status word: 21 = transmit queue empty, 19 = transmit queue not full, 17 = transmit occupancy at or below the transmit request level, 20 = receive queue not empty, 22 = receive queue full, 18 = receive occupancy at or above the receive request level.
- R8: `tx_dreq` is high when bit 9 (DMA enable) and bit 2 are both set and transmit occupancy is at or below the transmit request level. `tx_panic` follows the same rule using the transmit panic level.
- R9: `rx_dreq` is high when bit 9 and bit 1 are both set and receive occupancy is at or above the receive request level. `rx_panic` follows the same rule using the receive panic level.
- R10: The threshold word at address 2 is read/write. It holds the receive request level in bits 6:0, the transmit request level in bits 14:8, the receive panic level in bits 22:16 and the transmit panic level in bits 30:24. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | 1 | One-cycle strobe per audio bit clock |
| reg_wr | input | 1 | Bus write strobe |
| reg_rd | input | 1 | Bus read strobe (pops the receive queue at address 1) |
| reg_addr | input | 2 | Word address: 0 control/status, 1 data, 2 thresholds |
| reg_wdata | input | DATA_W | Bus write data |
| reg_rdata | output | DATA_W | Bus read data, combinational from the address |
| tx_word_req | input | 1 | Slot generator takes one transmit word |
| tx_word | output | DATA_W | Oldest transmit word |
| rx_word_vld | input | 1 | Slot generator delivers one receive word |
| rx_word | input | DATA_W | Received word |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_panic | output | 1 | Transmit panic request |
| rx_panic | output | 1 | Receive panic request |

## Verification
The bench builds the block with DEPTH=8 and CLR_TICKS=3, keeping LVL_W=7 and DATA_W=32. An eight-word queue means that random traffic regularly reaches the full and empty limits. This exercises the overflow and underflow errors and makes both threshold comparisons change state in both directions. A three-strobe delay leaves two intermediate strobes, where the bench can confirm that neither the clear nor the sync readback has happened early.

// File: rtl/afq_pkg.sv
package afq_pkg;
  // control/status bit positions, decoded by software
  localparam int B_EN      = 0;
  localparam int B_RXON    = 1;
  localparam int B_TXON    = 2;
  localparam int B_TXCLR   = 3;
  localparam int B_RXCLR   = 4;
  localparam int B_DMAEN   = 9;
  localparam int B_TXERR   = 15;
  localparam int B_RXERR   = 16;
  localparam int B_TXW     = 17;
  localparam int B_RXR     = 18;
  localparam int B_TXFREE  = 19;
  localparam int B_RXDATA  = 20;
  localparam int B_TXEMPTY = 21;
  localparam int B_RXFULL  = 22;
  localparam int B_SYNC    = 24;

  localparam logic [1:0] A_CSR  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_LVL  = 2'd2;

  // threshold compare used for the transmit direction
  function automatic logic at_or_below(logic [31:0] occ, logic [31:0] lvl);
    return occ <= lvl;
  endfunction

  // threshold compare used for the receive direction
  function automatic logic at_or_above(logic [31:0] occ, logic [31:0] lvl);
    return occ >= lvl;
  endfunction
endpackage

// File: rtl/afq_tick_delay.sv
module afq_tick_delay #(
  parameter int N = 2,
  localparam int CTW = $clog2(N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic done
);
  logic [CTW-1:0] cnt;
  logic           busy;

  assign busy = cnt != '0;
  assign done = tick && !start && (cnt == CTW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= CTW'(N);
    else if (tick && busy)  cnt <= cnt - 1'b1;
  end

  // R5/R6: a finished delay leaves the counter idle until restarted
  p_delay_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R5/R6: a start always arms the counter
  p_delay_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/afq_fifo.sv
module afq_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty,
  output logic              overflow,
  output logic              underflow
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic              do_push, do_pop;

  assign full      = count == CW'(DEPTH);
  assign empty     = count == '0;
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign overflow  = push && full;
  assign underflow = pop && empty;
  assign head      = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= wdata;
  end

  // R2: occupancy never exceeds the depth
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R5: a clear leaves the queue empty
  p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
  // R4: a full queue with no pop stays full (extra words dropped)
  p_full_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clr) |=> full);
endmodule

// File: rtl/afq_top.sv
module afq_top #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 64,
  parameter int CLR_TICKS = 2,
  parameter int LVL_W     = 7,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int NEV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_word_req,
  output logic [DATA_W-1:0] tx_word,
  input  logic              rx_word_vld,
  input  logic [DATA_W-1:0] rx_word,
  output logic              tx_dreq,
  output logic              rx_dreq,
  output logic              tx_panic,
  output logic              rx_panic
);
  import afq_pkg::*;

  logic en_q, rxon_q, txon_q, dmaen_q, txerr_q, rxerr_q, sync_wr_q, sync_rd_q;
  logic [LVL_W-1:0] rx_req_q, tx_req_q, rx_pan_q, tx_pan_q;

  // named bus events
  logic csr_wr, data_wr, data_rd, lvl_wr;
  assign csr_wr  = reg_wr && reg_addr == A_CSR;
  assign data_wr = reg_wr && reg_addr == A_DATA;
  assign data_rd = reg_rd && reg_addr == A_DATA;
  assign lvl_wr  = reg_wr && reg_addr == A_LVL;

  // slot-side events after gating
  logic tx_pop, rx_push;
  assign tx_pop  = tx_word_req && en_q && txon_q;
  assign rx_push = rx_word_vld && en_q && rxon_q;

  // delayed events: 0 = transmit clear, 1 = receive clear, 2 = sync echo
  logic [NEV-1:0] ev_start, ev_done;
  assign ev_start[0] = csr_wr && reg_wdata[B_TXCLR];
  assign ev_start[1] = csr_wr && reg_wdata[B_RXCLR];
  assign ev_start[2] = csr_wr && (reg_wdata[B_SYNC] != sync_wr_q);

  for (genvar g = 0; g < NEV; g++) begin : g_dly
    afq_tick_delay #(.N(CLR_TICKS)) u_dly (
      .clk(clk), .rst_n(rst_n), .start(ev_start[g]),
      .tick(bclk_tick), .done(ev_done[g])
    );
  end

  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_ovf, tx_unf, rx_ovf, rx_unf;
  logic [DATA_W-1:0] rx_head;

  afq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(ev_done[0]), .push(data_wr), .wdata(reg_wdata),
    .pop(tx_pop), .head(tx_word), .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .overflow(tx_ovf), .underflow(tx_unf)
  );

  afq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(ev_done[1]), .push(rx_push), .wdata(rx_word),
    .pop(data_rd), .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .overflow(rx_ovf), .underflow(rx_unf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; rxon_q <= 1'b0; txon_q <= 1'b0; dmaen_q <= 1'b0;
      txerr_q <= 1'b0; rxerr_q <= 1'b0; sync_wr_q <= 1'b0; sync_rd_q <= 1'b0;
      rx_req_q <= '0; tx_req_q <= '0; rx_pan_q <= '0; tx_pan_q <= '0;
    end else begin
      if (csr_wr) begin
        en_q      <= reg_wdata[B_EN];
        rxon_q    <= reg_wdata[B_RXON];
        txon_q    <= reg_wdata[B_TXON];
        dmaen_q   <= reg_wdata[B_DMAEN];
        sync_wr_q <= reg_wdata[B_SYNC];
      end
      // new error events win over a same-cycle write-one-to-clear
      txerr_q <= (txerr_q && !(csr_wr && reg_wdata[B_TXERR])) || tx_ovf || tx_unf;
      rxerr_q <= (rxerr_q && !(csr_wr && reg_wdata[B_RXERR])) || rx_ovf || rx_unf;
      if (ev_done[2]) sync_rd_q <= sync_wr_q;
      if (lvl_wr) begin
        rx_req_q <= reg_wdata[0  +: LVL_W];
        tx_req_q <= reg_wdata[8  +: LVL_W];
        rx_pan_q <= reg_wdata[16 +: LVL_W];
        tx_pan_q <= reg_wdata[24 +: LVL_W];
      end
    end
  end

  // threshold hits, ungated (status) and gated (DMA lines)
  logic tx_req_hit, rx_req_hit, tx_pan_hit, rx_pan_hit, tx_dma_ok, rx_dma_ok;
  assign tx_req_hit = at_or_below(32'(tx_cnt), 32'(tx_req_q));
  assign tx_pan_hit = at_or_below(32'(tx_cnt), 32'(tx_pan_q));
  assign rx_req_hit = at_or_above(32'(rx_cnt), 32'(rx_req_q));
  assign rx_pan_hit = at_or_above(32'(rx_cnt), 32'(rx_pan_q));
  assign tx_dma_ok  = dmaen_q && txon_q;
  assign rx_dma_ok  = dmaen_q && rxon_q;
  assign tx_dreq    = tx_dma_ok && tx_req_hit;
  assign tx_panic   = tx_dma_ok && tx_pan_hit;
  assign rx_dreq    = rx_dma_ok && rx_req_hit;
  assign rx_panic   = rx_dma_ok && rx_pan_hit;

  logic [DATA_W-1:0] csr_rd, lvl_rd;
  always_comb begin
    csr_rd = '0;
    csr_rd[B_EN]      = en_q;
    csr_rd[B_RXON]    = rxon_q;
    csr_rd[B_TXON]    = txon_q;
    csr_rd[B_DMAEN]   = dmaen_q;
    csr_rd[B_TXERR]   = txerr_q;
    csr_rd[B_RXERR]   = rxerr_q;
    csr_rd[B_TXW]     = tx_req_hit;
    csr_rd[B_RXR]     = rx_req_hit;
    csr_rd[B_TXFREE]  = !tx_full;
    csr_rd[B_RXDATA]  = !rx_empty;
    csr_rd[B_TXEMPTY] = tx_empty;
    csr_rd[B_RXFULL]  = rx_full;
    csr_rd[B_SYNC]    = sync_rd_q;
    lvl_rd = '0;
    lvl_rd[0  +: LVL_W] = rx_req_q;
    lvl_rd[8  +: LVL_W] = tx_req_q;
    lvl_rd[16 +: LVL_W] = rx_pan_q;
    lvl_rd[24 +: LVL_W] = tx_pan_q;
  end

  always_comb begin
    unique case (reg_addr)
      A_CSR:   reg_rdata = csr_rd;
      A_DATA:  reg_rdata = rx_head;
      A_LVL:   reg_rdata = lvl_rd;
      default: reg_rdata = '0;
    endcase
  end

  // R8: transmit DMA lines only when DMA and transmit are on
  p_tx_dma_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dreq || tx_panic) |-> (dmaen_q && txon_q));
  // R9: receive DMA lines only when DMA and receive are on
  p_rx_dma_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dreq || rx_panic) |-> (dmaen_q && rxon_q));
  // R4: error bit is sticky unless written with 1
  p_txerr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txerr_q && !(csr_wr && reg_wdata[B_TXERR])) |=> txerr_q);
  // R6: sync readback moves only when its delay finishes
  p_sync_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_done[2] |=> $stable(sync_rd_q));
  // R3: a gated-off pop leaves transmit occupancy alone
  p_tx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_word_req && !(en_q && txon_q) && !data_wr && !ev_done[0]) |=> $stable(tx_cnt));
endmodule

// File: tb/afq_top_test.sv
module afq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int CLR_TICKS  = 3;

  logic        clk = 1'b0, rst_n = 1'b0, bclk_tick = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, rx_word = '0;
  logic        tx_word_req = 1'b0, rx_word_vld = 1'b0;
  logic [31:0] reg_rdata, tx_word;
  logic        tx_dreq, rx_dreq, tx_panic, rx_panic;

  afq_top #(.DATA_W(32), .DEPTH(DEPTH), .CLR_TICKS(CLR_TICKS), .LVL_W(7)) uut (
    .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_word_req(tx_word_req), .tx_word(tx_word), .rx_word_vld(rx_word_vld),
    .rx_word(rx_word), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
    .tx_panic(tx_panic), .rx_panic(rx_panic)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] txq[$], rxq[$];
  bit m_en, m_rxon, m_txon, m_dma, m_txerr, m_rxerr, m_sync_wr, m_sync_rd;
  int m_rxreq, m_txreq, m_rxpan, m_txpan;
  localparam logic [31:0] ON_ALL = 32'h0000_0207;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_csr();
    logic [31:0] v = '0;
    v[0] = m_en; v[1] = m_rxon; v[2] = m_txon; v[9] = m_dma;
    v[15] = m_txerr; v[16] = m_rxerr;
    v[17] = txq.size() <= m_txreq;
    v[18] = rxq.size() >= m_rxreq;
    v[19] = txq.size() < DEPTH;
    v[20] = rxq.size() != 0;
    v[21] = txq.size() == 0;
    v[22] = rxq.size() == DEPTH;
    v[24] = m_sync_rd;
    return v;
  endfunction

  function automatic logic [31:0] exp_dma();
    logic [31:0] v = '0;
    v[0] = m_dma && m_txon && (txq.size() <= m_txreq);
    v[1] = m_dma && m_rxon && (rxq.size() >= m_rxreq);
    v[2] = m_dma && m_txon && (txq.size() <= m_txpan);
    v[3] = m_dma && m_rxon && (rxq.size() >= m_rxpan);
    return v;
  endfunction

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic bus_peek(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic wr_csr(logic [31:0] v);
    bus_write(2'd0, v);
    m_en = v[0]; m_rxon = v[1]; m_txon = v[2]; m_dma = v[9];
    if (v[15]) m_txerr = 0;
    if (v[16]) m_rxerr = 0;
    m_sync_wr = v[24];
  endtask

  task automatic check_state(string req);
    logic [31:0] v;
    bus_peek(2'd0, v);
    check({req, " csr"}, v, exp_csr());
    check({req, " dma lines"}, {28'd0, rx_panic, tx_panic, rx_dreq, tx_dreq}, exp_dma());
  endtask

  task automatic push_tx(logic [31:0] d);
    bus_write(2'd1, d);
    if (txq.size() < DEPTH) txq.push_back(d); else m_txerr = 1;
  endtask

  task automatic slot_pop();
    logic [31:0] w;
    @(negedge clk); tx_word_req = 1'b1; w = tx_word;
    @(negedge clk); tx_word_req = 1'b0;
    if (m_en && m_txon) begin
      if (txq.size() > 0) check("R2 tx order", w, txq.pop_front());
      else m_txerr = 1;
    end
  endtask

  task automatic slot_push(logic [31:0] d);
    @(negedge clk); rx_word_vld = 1'b1; rx_word = d;
    @(negedge clk); rx_word_vld = 1'b0;
    if (m_en && m_rxon) begin
      if (rxq.size() < DEPTH) rxq.push_back(d); else m_rxerr = 1;
    end
  endtask

  task automatic read_rx();
    logic [31:0] d;
    @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0; reg_addr = 2'd0;
    if (rxq.size() > 0) check("R2 rx order", d, rxq.pop_front());
    else m_rxerr = 1;
  endtask

  task automatic tick();
    @(negedge clk); bclk_tick = 1'b1;
    @(negedge clk); bclk_tick = 1'b0;
  endtask

  task automatic set_levels(int rq, int tq, int rp, int tp);
    logic [31:0] v;
    bus_write(2'd2, {1'b1, 7'(tp), 1'b1, 7'(rp), 1'b1, 7'(tq), 1'b1, 7'(rq)});
    m_rxreq = rq; m_txreq = tq; m_rxpan = rp; m_txpan = tp;
    bus_peek(2'd2, v);
    check("R10 threshold word", v, {1'b0, 7'(tp), 1'b0, 7'(rp), 1'b0, 7'(tq), 1'b0, 7'(rq)});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int unsigned seed = 32'd2024;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    bus_peek(2'd0, v);
    check("R1 csr after reset", v, 32'h002E_0000);
    bus_peek(2'd2, v);
    check("R1 thresholds after reset", v, 32'h0);
    check("R1 dma lines after reset", {28'd0, rx_panic, tx_panic, rx_dreq, tx_dreq}, 32'h0);

    // R10 / R8 / R9: thresholds and DMA lines with empty queues
    set_levels(2, 3, 6, 1);
    wr_csr(ON_ALL);
    check_state("R8/R9 empty queues");

    // constrained random traffic
    for (int i = 0; i < 500; i++) begin
      int op = $urandom % 5;
      case (op)
        0: push_tx($urandom);
        1: slot_pop();
        2: slot_push($urandom);
        3: read_rx();
        default: begin
          logic [31:0] c = '0;
          c[0] = ($urandom % 8) != 0;
          c[1] = ($urandom % 4) != 0;
          c[2] = ($urandom % 4) != 0;
          c[9] = ($urandom % 4) != 0;
          c[15] = ($urandom % 3) == 0;
          c[16] = ($urandom % 3) == 0;
          c[24] = m_sync_wr;
          wr_csr(c);
        end
      endcase
      check_state("R7/R8/R9/R4");
      if (i == 250) set_levels(5, 6, 7, 2);
    end

    // R3: gated-off slot handshakes
    wr_csr(ON_ALL | 32'h0001_8000);
    push_tx(32'hA5A5_0001);
    wr_csr(32'h0000_0203);
    slot_pop();
    check_state("R3 tx pop ignored");
    wr_csr(32'h0000_0205);
    slot_push(32'h1234_5678);
    check_state("R3 rx push ignored");

    // R4: overflow / underflow and write-one-to-clear
    wr_csr(ON_ALL);
    while (txq.size() < DEPTH) push_tx($urandom);
    check_state("R4 tx full no error");
    push_tx(32'hDEAD_BEEF);
    check_state("R4 tx overflow");
    wr_csr(ON_ALL | 32'h0000_8000);
    check_state("R4 tx error cleared");
    while (rxq.size() > 0) read_rx();
    read_rx();
    check_state("R4 rx underflow");
    while (rxq.size() < DEPTH) slot_push($urandom);
    slot_push(32'h0BAD_0BAD);
    check_state("R4 rx overflow kept sticky");

    // R5: delayed clear of both queues
    wr_csr(ON_ALL | 32'h0001_8018);
    repeat (CLR_TICKS - 1) tick();
    check_state("R5 clear not yet taken");
    tick();
    txq.delete(); rxq.delete();
    check_state("R5 clear taken");

    // R6: sync echo
    wr_csr(ON_ALL | 32'h0100_0000);
    repeat (CLR_TICKS - 1) tick();
    check_state("R6 sync still old");
    tick();
    m_sync_rd = 1;
    check_state("R6 sync echoed");

    // R8/R9: threshold edges after refill
    set_levels(0, 0, 1, 0);
    slot_push(32'h1);
    push_tx(32'h2);
    check_state("R8/R9 boundary levels");

    finished = 1;
    summary();
    $finish;
  end
endmodule